// File: doc/BRIEF.md
# Radix Page Protection Check and Storage-Interrupt Formatter

This block sits at the end of a radix translation walk. It takes the leaf page-table entry that the walker found, together with the kind of access (load, store or instruction fetch), the privilege state of the requester, and whether the check belongs to the process-level or the partition-level stage. It works out which of read, write and execute the entry grants. For a supervisor access to a non-privileged process-level entry, it also folds in a per-context authority mask.

When the access is not allowed, or when an instruction fetch targets a page marked as non-idempotent I/O, the block produces a complete interrupt description. This covers the interrupt class, the cause word, the value for the error-code field, and write enables with data for the status, faulting-address and guest-real-address registers. The walker and the register file consume these results directly.

The decision logic is combinational. A single register stage captures its results and raises a one-cycle valid strobe one clock after each request.

Top module: `radix_prot_fault`

## Requirements
- R1: When entry bits [5:4] equal 2'b10 (non-idempotent I/O) and the access code is 2 (fetch), the result is a fault whose cause has bit 28 set and bit 27 clear, and whose granted permission is 3'b000.
- R2: For a process-level check (req_part=0) of an entry with bit 3 set (privileged) while req_pr=1, the granted permission is 3'b000.
- R3: In all other cases where req_pr=1, entry bit 3 is set, or req_part=1, the granted permission equals entry bits [2:0]. Bit 0 is read, bit 1 is write and bit 2 is execute.
- R4: For a process-level, non-privileged entry with req_pr=0, the granted permission is entry bits [2:0] ANDed with req_amr, using the same bit order.
- R5: Access code 0 needs read, 1 needs write, 2 needs execute, and 3 is treated as read. A needed permission that is missing from the granted set raises a fault with cause bit 27.
- R6: A process-level fault on a fetch has class 3 (instruction storage) and an error code equal to the cause. It does not enable a status or address write.
- R7: A process-level fault on a load or store has class 4 (data storage) and an error code of 0. It enables both the status write (value = cause) and the address write (value = req_ea). For access code 1, cause bit 25 is set.
- R8: A partition-level fault has class 5 (hypervisor instruction storage) for a fetch and class 6 (hypervisor data storage) otherwise. Both enable the guest-real-address write with value req_gra. Class 6 also writes status and address, with the store bit as in R7, and class 5 places the cause in the error code.
- R9: A partition-level fault with req_pde_walk=1 additionally sets cause bit 20.
- R10: Without a fault, the class is 0, the cause and error code are 0, and all three write enables are low.
- R11: Results appear exactly one clock after a request. out_valid is high only in that cycle, and every write enable is low while out_valid is low.
- R12: During and right after reset, out_valid and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_pte | input | PTE_W | Leaf page-table entry |
| req_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch, 3 load |
| req_pr | input | 1 | Problem (user) state |
| req_part | input | 1 | 1 = partition-level check, 0 = process-level |
| req_amr | input | 3 | Authority-mask permissions {x,w,r} |
| req_pde_walk | input | 1 | Address being translated was a guest directory entry |
| req_ea | input | EA_W | Faulting effective address |
| req_gra | input | EA_W | Guest real address |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 1 | Access refused |
| out_perm | output | 3 | Granted permissions {x,w,r} |
| out_class | output | 3 | Interrupt class |
| out_cause | output | CAUSE_W | Cause word |
| out_err_code | output | CAUSE_W | Error-code value |
| out_status_we | output | 1 | Status register write enable |
| out_status_val | output | CAUSE_W | Status register value |
| out_addr_we | output | 1 | Faulting-address register write enable |
| out_addr_val | output | EA_W | Faulting-address value |
| out_gra_we | output | 1 | Guest-real-address register write enable |
| out_gra_val | output | EA_W | Guest-real-address value |

## Verification
The block keeps no state apart from the output register. A wrong decision in the permission merge or in the class selection therefore shows up in the very next strobe as a wrong perm, class or cause value. No later transaction can hide it. A stuck or late valid, or a write enable that leaks outside the strobe, shows up on the first idle cycle after a request. Random entries sweep all privilege, scope and mask combinations. Directed cases cover guarded fetch, directory-walk faults and access code 3.

// File: rtl/radix_pc_pkg.sv
package radix_pc_pkg;
   typedef enum logic [2:0] {
      ICLS_NONE = 3'd0,
      ICLS_ISEG = 3'd1,
      ICLS_DSEG = 3'd2,
      ICLS_ISI  = 3'd3,
      ICLS_DSI  = 3'd4,
      ICLS_HISI = 3'd5,
      ICLS_HDSI = 3'd6
   } icls_e;

   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;
   localparam logic [1:0] ACC_ALT   = 2'd3;

   localparam int PERM_N = 3;
endpackage

// File: rtl/radix_perm_eval.sv
module radix_perm_eval
   import radix_pc_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int PERM_LSB = 0,
   parameter int PRIV_BIT = 3,
   parameter int ATT_LSB  = 4,
   parameter logic [1:0] NIIO_CODE = 2'b10
) (
   input  logic [PTE_W-1:0]  pte,
   input  logic [1:0]        acc,
   input  logic              pr,
   input  logic              part,
   input  logic [PERM_N-1:0] amr,
   output logic [PERM_N-1:0] perm,
   output logic              guard,
   output logic              prot_miss
);
   logic [PERM_N-1:0] eaa;
   logic [PERM_N-1:0] need;
   logic [PERM_N-1:0] merged;
   logic [1:0]        acc_eff;
   logic              priv;
   logic              fetch;

   assign eaa     = pte[PERM_LSB +: PERM_N];
   assign priv    = pte[PRIV_BIT];
   assign acc_eff = (acc == ACC_ALT) ? ACC_LOAD : acc;
   assign fetch   = (acc_eff == ACC_FETCH);
   assign guard   = fetch && (pte[ATT_LSB +: 2] == NIIO_CODE);

   for (genvar g = 0; g < PERM_N; g++) begin : g_need
      assign need[g] = (acc_eff == 2'(g));
   end

   always_comb begin
      if (!part && priv && pr)
         merged = '0;
      else if (pr || priv || part)
         merged = eaa;
      else
         merged = eaa & amr;
   end

   assign perm      = guard ? '0 : merged;
   assign prot_miss = !guard && ((need & ~merged) != '0);
endmodule

// File: rtl/radix_fault_fmt.sv
module radix_fault_fmt
   import radix_pc_pkg::*;
#(
   parameter int CAUSE_W  = 32,
   parameter int CB_GUARD = 28,
   parameter int CB_PROT  = 27,
   parameter int CB_STORE = 25,
   parameter int CB_TABLE = 20
) (
   input  logic               guard,
   input  logic               prot_miss,
   input  logic [1:0]         acc,
   input  logic               part,
   input  logic               pde_walk,
   output logic               fault,
   output icls_e              icls,
   output logic [CAUSE_W-1:0] cause,
   output logic [CAUSE_W-1:0] err_code,
   output logic               status_we,
   output logic               addr_we,
   output logic               gra_we
);
   logic fetch;
   logic inst_cls;
   logic data_cls;

   assign fetch = (acc == ACC_FETCH);
   assign fault = guard || prot_miss;

   always_comb begin
      cause = '0;
      if (guard)          cause[CB_GUARD] = 1'b1;
      else if (prot_miss) cause[CB_PROT]  = 1'b1;
      if (fault && part && pde_walk)    cause[CB_TABLE] = 1'b1;
      if (fault && (acc == ACC_STORE))  cause[CB_STORE] = 1'b1;
   end

   always_comb begin
      if (!fault)     icls = ICLS_NONE;
      else if (part)  icls = fetch ? ICLS_HISI : ICLS_HDSI;
      else            icls = fetch ? ICLS_ISI  : ICLS_DSI;
   end

   assign inst_cls  = (icls == ICLS_ISI) || (icls == ICLS_HISI);
   assign data_cls  = (icls == ICLS_DSI) || (icls == ICLS_HDSI);
   assign err_code  = inst_cls ? cause : '0;
   assign status_we = data_cls;
   assign addr_we   = data_cls;
   assign gra_we    = fault && part;
endmodule

// File: rtl/radix_prot_fault.sv
module radix_prot_fault
   import radix_pc_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int EA_W     = 64,
   parameter int CAUSE_W  = 32,
   parameter int PERM_LSB = 0,
   parameter int PRIV_BIT = 3,
   parameter int ATT_LSB  = 4,
   parameter int CB_GUARD = 28,
   parameter int CB_PROT  = 27,
   parameter int CB_STORE = 25,
   parameter int CB_TABLE = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [PTE_W-1:0]   req_pte,
   input  logic [1:0]         req_acc,
   input  logic               req_pr,
   input  logic               req_part,
   input  logic [2:0]         req_amr,
   input  logic               req_pde_walk,
   input  logic [EA_W-1:0]    req_ea,
   input  logic [EA_W-1:0]    req_gra,
   output logic               out_valid,
   output logic               out_fault,
   output logic [2:0]         out_perm,
   output logic [2:0]         out_class,
   output logic [CAUSE_W-1:0] out_cause,
   output logic [CAUSE_W-1:0] out_err_code,
   output logic               out_status_we,
   output logic [CAUSE_W-1:0] out_status_val,
   output logic               out_addr_we,
   output logic [EA_W-1:0]    out_addr_val,
   output logic               out_gra_we,
   output logic [EA_W-1:0]    out_gra_val
);
   localparam int TOP_CB = (CB_GUARD > CB_PROT) ? CB_GUARD : CB_PROT;

   if (PERM_LSB + PERM_N > PTE_W || PRIV_BIT >= PTE_W || ATT_LSB + 2 > PTE_W) begin : g_bad_pte
      $error("entry field position outside PTE_W");
   end
   if (TOP_CB >= CAUSE_W || CB_STORE >= CAUSE_W || CB_TABLE >= CAUSE_W) begin : g_bad_cause
      $error("cause bit outside CAUSE_W");
   end

   logic [PERM_N-1:0]  c_perm;
   logic               c_guard, c_miss, c_fault;
   icls_e              c_icls;
   logic [CAUSE_W-1:0] c_cause, c_err;
   logic               c_swe, c_awe, c_gwe;

   radix_perm_eval #(
      .PTE_W(PTE_W), .PERM_LSB(PERM_LSB), .PRIV_BIT(PRIV_BIT), .ATT_LSB(ATT_LSB),
      .NIIO_CODE(2'b10)
   ) u_eval (
      .pte(req_pte), .acc(req_acc), .pr(req_pr), .part(req_part), .amr(req_amr),
      .perm(c_perm), .guard(c_guard), .prot_miss(c_miss)
   );

   radix_fault_fmt #(
      .CAUSE_W(CAUSE_W), .CB_GUARD(CB_GUARD), .CB_PROT(CB_PROT),
      .CB_STORE(CB_STORE), .CB_TABLE(CB_TABLE)
   ) u_fmt (
      .guard(c_guard), .prot_miss(c_miss), .acc(req_acc), .part(req_part),
      .pde_walk(req_pde_walk), .fault(c_fault), .icls(c_icls), .cause(c_cause),
      .err_code(c_err), .status_we(c_swe), .addr_we(c_awe), .gra_we(c_gwe)
   );

   logic r_swe, r_awe, r_gwe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_fault      <= 1'b0;
         out_perm       <= '0;
         out_class      <= 3'(ICLS_NONE);
         out_cause      <= '0;
         out_err_code   <= '0;
         out_status_val <= '0;
         out_addr_val   <= '0;
         out_gra_val    <= '0;
         r_swe          <= 1'b0;
         r_awe          <= 1'b0;
         r_gwe          <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_fault      <= c_fault;
            out_perm       <= c_perm;
            out_class      <= 3'(c_icls);
            out_cause      <= c_cause;
            out_err_code   <= c_err;
            out_status_val <= c_cause;
            out_addr_val   <= req_ea;
            out_gra_val    <= req_gra;
            r_swe          <= c_swe;
            r_awe          <= c_awe;
            r_gwe          <= c_gwe;
         end
      end
   end

   assign out_status_we = r_swe && out_valid;
   assign out_addr_we   = r_awe && out_valid;
   assign out_gra_we    = r_gwe && out_valid;
endmodule

// File: rtl/radix_prot_fault_chk.sv
module radix_prot_fault_chk #(
   parameter int PTE_W    = 64,
   parameter int EA_W     = 64,
   parameter int CAUSE_W  = 32,
   parameter int PRIV_BIT = 3,
   parameter int CB_STORE = 25
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [PTE_W-1:0]   req_pte,
   input logic [1:0]         req_acc,
   input logic               req_pr,
   input logic               req_part,
   input logic               out_valid,
   input logic               out_fault,
   input logic [2:0]         out_perm,
   input logic [2:0]         out_class,
   input logic [CAUSE_W-1:0] out_cause,
   input logic               out_status_we,
   input logic               out_addr_we,
   input logic               out_gra_we
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R11
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R11
   AST_WE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !(out_status_we || out_addr_we || out_gra_we)); // R11
   AST_NOFAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fault) |-> (out_class == 3'd0 && out_cause == '0)); // R10
   AST_GRA_HYP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_gra_we) |-> (out_class == 3'd5 || out_class == 3'd6)); // R8
   AST_FETCH_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class == 3'd3) |-> !(out_status_we || out_addr_we)); // R6
   AST_STORE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_acc == 2'd1) |=> (!out_status_we || out_cause[CB_STORE])); // R7
   AST_USER_PRIV_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_part && req_pr && req_pte[PRIV_BIT]) |=> (out_perm == 3'b000)); // R2
endmodule

bind radix_prot_fault radix_prot_fault_chk #(
   .PTE_W(PTE_W), .EA_W(EA_W), .CAUSE_W(CAUSE_W), .PRIV_BIT(PRIV_BIT), .CB_STORE(CB_STORE)
) u_chk (.*);

// File: tb/sim_radix_prot_fault.sv
module sim_radix_prot_fault;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_pte = '0;
   logic [1:0]  req_acc = '0;
   logic        req_pr = 1'b0;
   logic        req_part = 1'b0;
   logic [2:0]  req_amr = '0;
   logic        req_pde_walk = 1'b0;
   logic [63:0] req_ea = '0;
   logic [63:0] req_gra = '0;
   logic        out_valid, out_fault, out_status_we, out_addr_we, out_gra_we;
   logic [2:0]  out_perm, out_class;
   logic [31:0] out_cause, out_err_code, out_status_val;
   logic [63:0] out_addr_val, out_gra_val;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   radix_prot_fault u0 (.*);

   logic [2:0]  e_perm, e_class;
   logic        e_fault, e_swe, e_awe, e_gwe;
   logic [31:0] e_cause, e_err;
   string       p_tag, c_tag;

   task automatic model();
      logic [1:0] a;
      logic fetch, guard, miss;
      a = (req_acc == 2'd3) ? 2'd0 : req_acc;
      fetch = (a == 2'd2);
      if (!req_part && req_pte[3] && req_pr) begin e_perm = 3'b000; p_tag = "R2"; end
      else if (req_pr || req_pte[3] || req_part) begin e_perm = req_pte[2:0]; p_tag = "R3"; end
      else begin e_perm = req_pte[2:0] & req_amr; p_tag = "R4"; end
      guard = fetch && (req_pte[5:4] == 2'b10);
      if (guard) begin e_perm = 3'b000; p_tag = "R1"; end
      miss = !guard && !e_perm[a];
      e_fault = guard || miss;
      e_cause = '0;
      if (guard) e_cause[28] = 1'b1;
      else if (miss) e_cause[27] = 1'b1;
      if (e_fault && req_part && req_pde_walk) e_cause[20] = 1'b1;
      if (e_fault && req_acc == 2'd1) e_cause[25] = 1'b1;
      if (!e_fault) begin e_class = 3'd0; c_tag = "R10"; end
      else if (req_part) begin e_class = fetch ? 3'd5 : 3'd6; c_tag = "R8"; end
      else if (fetch) begin e_class = 3'd3; c_tag = "R6"; end
      else begin e_class = 3'd4; c_tag = "R7"; end
      e_err = (e_class == 3'd3 || e_class == 3'd5) ? e_cause : '0;
      e_swe = (e_class == 3'd4 || e_class == 3'd6);
      e_awe = e_swe;
      e_gwe = e_fault && req_part;
   endtask

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic run_one();
      model();
      req_valid = 1'b1;
      @(negedge clk);
      chk("R11", "valid", 64'(out_valid), 64'd1);
      chk(p_tag, "perm", 64'(out_perm), 64'(e_perm));
      chk(guard_tag(), "fault", 64'(out_fault), 64'(e_fault));
      chk(c_tag, "class", 64'(out_class), 64'(e_class));
      chk((req_part && req_pde_walk) ? "R9" : c_tag, "cause", 64'(out_cause), 64'(e_cause));
      chk(c_tag, "err", 64'(out_err_code), 64'(e_err));
      chk(c_tag, "we", {61'd0, out_status_we, out_addr_we, out_gra_we}, {61'd0, e_swe, e_awe, e_gwe});
      if (e_swe) begin
         chk(c_tag, "status", 64'(out_status_val), 64'(e_cause));
         chk(c_tag, "addr", out_addr_val, req_ea);
      end
      if (e_gwe) chk("R8", "gra", out_gra_val, req_gra);
   endtask

   function automatic string guard_tag();
      return (p_tag == "R1") ? "R1" : "R5";
   endfunction

   task automatic idle_one();
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11", "idle", {60'd0, out_valid, out_status_we, out_addr_we, out_gra_we}, 64'd0);
   endtask

   task automatic set(logic [63:0] pte, logic [1:0] acc, logic pr, logic part,
                      logic [2:0] amr, logic pde);
      req_pte = pte; req_acc = acc; req_pr = pr; req_part = part;
      req_amr = amr; req_pde_walk = pde;
      req_ea = {$urandom, $urandom}; req_gra = {$urandom, $urandom};
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R12", "reset", {60'd0, out_valid, out_status_we, out_addr_we, out_gra_we}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "post-reset", {63'd0, out_valid}, 64'd0);
      // R1 guarded fetch, process and partition with directory walk (R9)
      set(64'h27, 2'd2, 1'b0, 1'b0, 3'b111, 1'b0); run_one();
      set(64'h27, 2'd2, 1'b0, 1'b1, 3'b111, 1'b1); run_one();
      // R2 privileged entry in user state
      set(64'h0F, 2'd0, 1'b1, 1'b0, 3'b111, 1'b0); run_one();
      // R3 partition, user state full grant
      set(64'h07, 2'd1, 1'b1, 1'b1, 3'b000, 1'b0); run_one();
      // R4 AMR removes write; R7 store bit
      set(64'h07, 2'd1, 1'b0, 1'b0, 3'b101, 1'b0); run_one();
      // R5 access code 3 treated as read
      set(64'h02, 2'd3, 1'b0, 1'b1, 3'b111, 1'b0); run_one();
      set(64'h01, 2'd3, 1'b1, 1'b0, 3'b000, 1'b0); run_one();
      // R8 partition store fault with walk flag
      set(64'h05, 2'd1, 1'b0, 1'b1, 3'b111, 1'b1); run_one();
      idle_one();
      for (int i = 0; i < 400; i++) begin
         set({$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom),
             3'($urandom), 1'($urandom));
         if (($urandom % 5) == 0) idle_one();
         run_one();
      end
      idle_one();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule